// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that does not drive its own bus commands. Instead, the processor puts out a 3-bit status code, and this block rebuilds the separate command strobes from it. The strobes cover memory read and write, I/O read and write, and interrupt acknowledge. The block also produces an address latch pulse, a data buffer enable and a transfer direction.

Each bus cycle is bounded by the passive status code. A cycle opens when the status leaves the passive value. It closes when the status returns to passive. The command for the cycle follows one clock after the latch pulse. The direction line is settled at the latch pulse, so it is already valid before the buffer turns on.

The status code is sampled on the rising clock edge. Every output is a register.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is low at a clock edge, the outputs after that edge are as follows: all five command strobes high, `addr_latch` low, `buf_en` low and `dir_tx` low.
- R2: After reset is released, a non-passive status (anything other than 111) is ignored until at least one edge has sampled 111.
- R3: A cycle starts when an edge samples a non-passive code and the previous edge sampled 111. After that edge, `addr_latch` is high for exactly one clock and no command is active.
- R4: If the code is still sampled at the next edge, the command for the code goes low after that edge. The codes map as follows: 000 drives `int_ack_n`, 001 drives `io_rd_n`, 010 drives `io_wr_n`, 100 and 101 drive `mem_rd_n`, and 110 drives `mem_wr_n`.
- R5: Code 011 (halt) gives the latch pulse but never asserts a command strobe or `buf_en`.
- R6: A command stays asserted while non-passive codes are sampled. It is released after the first edge that samples 111.
- R7: If a non-passive code is sampled at only one edge before 111, the cycle gives a latch pulse and no command.
- R8: A change from one non-passive code to another during a cycle is ignored. The running command is kept, and no new latch pulse occurs.
- R9: At most one command strobe is low at any time.
- R10: `buf_en` is high exactly while a command strobe is low.
- R11: `dir_tx` is 1 (transmit) for codes 010 and 110 and 0 (receive) for all other cycles. It takes its value with the latch pulse and does not change while `buf_en` is high.
- R12: A single edge that samples 111 between two cycles is enough to start the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status code is sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stat_code | input | 3 | Encoded bus status from the processor; 111 means passive |
| mem_rd_n | output | 1 | Memory read command (also used for instruction fetch), active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| int_ack_n | output | 1 | Interrupt acknowledge command, active low |
| addr_latch | output | 1 | One-clock address latch strobe at the start of a cycle |
| buf_en | output | 1 | Data buffer enable, active high |
| dir_tx | output | 1 | Buffer direction: 1 transmit, 0 receive |

## Verification
A wrong phase state shows up at the ports within one or two clocks. It appears either as a missing or repeated latch pulse, or as a command that starts a clock early, starts a clock late, or outlives the passive code. A stale captured code shows up as the wrong strobe, or as a wrong `dir_tx` in the latch clock. A lost record of the previous status shows up as a cycle started straight out of reset, or as a latch pulse in the middle of a cycle. The bench sweeps every code with several hold lengths and with back-to-back starts, and checks the outputs in every clock.

// File: rtl/bsc_pkg.sv
// Shared constants, phase type and decode helpers for the bus status
// command decoder. Assumes a 3-bit status code with 111 as passive.
package bsc_pkg;

    localparam int CODE_W  = 3;
    localparam int NUM_CMD = 5;

    // Command bit positions inside the internal active-high vector.
    localparam int CMD_MRD  = 0;
    localparam int CMD_MWR  = 1;
    localparam int CMD_IORD = 2;
    localparam int CMD_IOWR = 3;
    localparam int CMD_INTA = 4;

    localparam logic [CODE_W-1:0] SC_INTA    = 3'b000;
    localparam logic [CODE_W-1:0] SC_IORD    = 3'b001;
    localparam logic [CODE_W-1:0] SC_IOWR    = 3'b010;
    localparam logic [CODE_W-1:0] SC_HALT    = 3'b011;
    localparam logic [CODE_W-1:0] SC_FETCH   = 3'b100;
    localparam logic [CODE_W-1:0] SC_MRD     = 3'b101;
    localparam logic [CODE_W-1:0] SC_MWR     = 3'b110;
    localparam logic [CODE_W-1:0] SC_PASSIVE = 3'b111;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2
    } phase_t;

    // Map a status code to a one-hot active-high command vector.
    function automatic logic [NUM_CMD-1:0] cmd_select(input logic [CODE_W-1:0] code);
        logic [NUM_CMD-1:0] v;
        v = '0;
        case (code)
            SC_INTA:          v[CMD_INTA] = 1'b1;
            SC_IORD:          v[CMD_IORD] = 1'b1;
            SC_IOWR:          v[CMD_IOWR] = 1'b1;
            SC_FETCH, SC_MRD: v[CMD_MRD]  = 1'b1;
            SC_MWR:           v[CMD_MWR]  = 1'b1;
            default:          v = '0;
        endcase
        return v;
    endfunction

    // True for codes that move data out of the processor.
    function automatic logic code_is_write(input logic [CODE_W-1:0] code);
        return (code == SC_IOWR) || (code == SC_MWR);
    endfunction

endpackage

// File: rtl/bsc_status_tracker.sv
// Remembers the status sampled at the previous edge. It flags a cycle start
// when the status goes from passive to non-passive. Assumes that reset loads
// a non-passive history, so a passive code must be seen after reset first.
module bsc_status_tracker
    import bsc_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    output logic         start,
    output logic         passive
);

    logic [W-1:0] prev_q;

    // Status history register; reset value is deliberately non-passive.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= code;
    end

    // Passive detect and passive-to-active edge detect.
    always_comb begin
        passive = (code == W'(SC_PASSIVE));
        start   = (prev_q == W'(SC_PASSIVE)) && !passive;
    end

endmodule

// File: rtl/bsc_cycle_fsm.sv
// Bus cycle phase sequencer: idle -> address (latch pulse) -> command.
// It captures the status code at the start of a cycle and ignores later
// non-passive changes. Assumes that start is only meaningful while idle.
module bsc_cycle_fsm
    import bsc_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         passive,
    input  logic [W-1:0] code,
    output phase_t       phase,
    output logic [W-1:0] cur_code,
    output logic         latch
);

    phase_t       ph_q, ph_d;
    logic [W-1:0] cc_q;
    logic         lat_q;

    // Next-phase selection.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (start)   ph_d = PH_ADDR;
            PH_ADDR: ph_d = passive ? PH_IDLE : PH_CMD;
            PH_CMD:  if (passive) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase, captured code and latch pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cc_q  <= SC_PASSIVE;
            lat_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            lat_q <= (ph_q == PH_IDLE) && start;
            if ((ph_q == PH_IDLE) && start) cc_q <= code;
        end
    end

    assign phase    = ph_q;
    assign cur_code = cc_q;
    assign latch    = lat_q;

    p_latch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q |=> !lat_q);

    p_latch_in_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q |-> (ph_q == PH_ADDR));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_CMD) && !passive |=> !lat_q);

endmodule

// File: rtl/bsc_strobe_drv.sv
// Drives the registered active-low command strobes, the buffer enable and
// the direction. Commands open one clock after the latch pulse and close on
// a passive code. Assumes the phase and captured code from the sequencer.
module bsc_strobe_drv
    import bsc_pkg::*;
#(
    parameter int W = CODE_W,
    parameter int N = NUM_CMD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_t       phase,
    input  logic [W-1:0] cur_code,
    input  logic         passive,
    input  logic         start,
    input  logic [W-1:0] code,
    output logic [N-1:0] cmd_n,
    output logic         buf_en,
    output logic         dir_tx
);

    logic [N-1:0] nxt_act;
    logic         buf_q;
    logic         dir_q;

    // Next active-high command vector for this clock.
    always_comb begin
        nxt_act = '0;
        case (phase)
            PH_ADDR: if (!passive) nxt_act = N'(cmd_select(cur_code));
            PH_CMD:  if (!passive) nxt_act = ~cmd_n;
            default: nxt_act = '0;
        endcase
    end

    // One active-low register per command line.
    for (genvar gi = 0; gi < N; gi++) begin : g_cmd
        logic r_n;
        always_ff @(posedge clk) begin
            if (!rst_n) r_n <= 1'b1;
            else        r_n <= ~nxt_act[gi];
        end
        assign cmd_n[gi] = r_n;
    end

    // Buffer enable follows the presence of any command.
    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= 1'b0;
        else        buf_q <= |nxt_act;
    end

    // Direction is taken at cycle start, together with the latch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= 1'b0;
        else if ((phase == PH_IDLE) && start) dir_q <= code_is_write(code);
    end

    assign buf_en = buf_q;
    assign dir_tx = dir_q;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> ((&cmd_n) && !buf_q && !dir_q));

    p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cmd_n) <= 1);

    p_buf_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        buf_q == !(&cmd_n));

    p_dir_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_q |-> $stable(dir_q));

    p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD) && (cur_code == W'(SC_HALT)) |-> ((&cmd_n) && !buf_q));

    p_end_on_passive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cmd_n) && passive |=> (&cmd_n));

endmodule

// File: rtl/bus_cmd_decoder.sv
// Top level of the bus status command decoder. It joins the status tracker,
// the cycle sequencer and the strobe driver, and spreads the command vector
// onto named pins. Assumes a single clock domain for stat_code.
module bus_cmd_decoder
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] stat_code,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              int_ack_n,
    output logic              addr_latch,
    output logic              buf_en,
    output logic              dir_tx
);

    logic              start, passive;
    phase_t            phase;
    logic [CODE_W-1:0] cur_code;
    logic [NUM_CMD-1:0] cmd_n;

    bsc_status_tracker #(.W(CODE_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .code(stat_code),
        .start(start), .passive(passive)
    );

    bsc_cycle_fsm #(.W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .passive(passive),
        .code(stat_code), .phase(phase), .cur_code(cur_code), .latch(addr_latch)
    );

    bsc_strobe_drv #(.W(CODE_W), .N(NUM_CMD)) u_drv (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cur_code(cur_code),
        .passive(passive), .start(start), .code(stat_code),
        .cmd_n(cmd_n), .buf_en(buf_en), .dir_tx(dir_tx)
    );

    assign mem_rd_n  = cmd_n[CMD_MRD];
    assign mem_wr_n  = cmd_n[CMD_MWR];
    assign io_rd_n   = cmd_n[CMD_IORD];
    assign io_wr_n   = cmd_n[CMD_IOWR];
    assign int_ack_n = cmd_n[CMD_INTA];

    p_cmd_after_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch && !passive && (cur_code != SC_HALT) |=> !(&cmd_n));

    p_no_cmd_with_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |-> (&cmd_n));

endmodule

// File: tb/sim_bus_cmd_decoder.sv
module sim_bus_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stat_code = 3'b101;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n;
    logic addr_latch, buf_en, dir_tx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bus_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .stat_code(stat_code),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .int_ack_n(int_ack_n), .addr_latch(addr_latch),
        .buf_en(buf_en), .dir_tx(dir_tx)
    );

    // Expected strobe index (0 mem rd, 1 mem wr, 2 io rd, 3 io wr, 4 int ack).
    function automatic int exp_idx(input logic [2:0] c);
        case (c)
            3'b000: return 4;
            3'b001: return 2;
            3'b010: return 3;
            3'b100, 3'b101: return 0;
            3'b110: return 1;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string req, input logic lat, input int idx,
                       input bit dchk, input logic dexp);
        logic [6:0] act, exp;
        act = {addr_latch, buf_en, int_ack_n, io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
        exp = {lat, (idx >= 0), (idx >= 0) ? ~(5'b1 << idx) : 5'h1f};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {latch,buf,cmd_n} actual=%b expected=%b", req, act, exp);
        end
        if (dchk) begin
            total++;
            if (dir_tx !== dexp) begin
                bad++;
                $display("FAIL %s: dir_tx actual=%b expected=%b", req, dir_tx, dexp);
            end
        end
    endtask

    // Run one cycle with code c sampled at h edges; leaves 111 driven.
    task automatic run_cycle(input logic [2:0] c, input int h);
        logic d;
        d = (c == 3'b010) || (c == 3'b110);
        stat_code = c;
        @(negedge clk);
        chk("R3 latch pulse", 1'b1, -1, 1'b1, d);   // R11 direction set with latch
        if (h == 1) stat_code = 3'b111;
        for (int i = 1; i < h; i++) begin
            @(negedge clk);
            if (c == 3'b011) chk("R5 halt quiet", 1'b0, -1, 1'b0, 1'b0);
            else chk("R4 R6 command held", 1'b0, exp_idx(c), 1'b1, d);
            if (i == h - 1) stat_code = 3'b111;
        end
        @(negedge clk);
        if (h == 1) chk("R7 single-clock cycle", 1'b0, -1, 1'b0, 1'b0);
        else        chk("R6 release on passive", 1'b0, -1, 1'b0, 1'b0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset state", 1'b0, -1, 1'b1, 1'b0);
        rst_n = 1'b1;
        // R2: non-passive held since reset is ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 no start before passive", 1'b0, -1, 1'b0, 1'b0);
        end
        stat_code = 3'b111;
        @(negedge clk);
        chk("R2 idle on passive", 1'b0, -1, 1'b0, 1'b0);

        // Sweep every non-passive code with several hold lengths; R12 back to back.
        for (int h = 1; h <= 4; h++) begin
            for (int c = 0; c < 7; c++) begin
                run_cycle(3'(c), h);
            end
        end

        // R8: mid-cycle code change ignored
        stat_code = 3'b101;
        @(negedge clk);
        chk("R8 latch", 1'b1, -1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 mem read on", 1'b0, 0, 1'b1, 1'b0);
        stat_code = 3'b010;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 change ignored", 1'b0, 0, 1'b1, 1'b0);
        end
        stat_code = 3'b111;
        @(negedge clk);
        chk("R8 release", 1'b0, -1, 1'b0, 1'b0);

        // R12: a cycle directly after a passive gap of several clocks
        repeat (2) @(negedge clk);
        run_cycle(3'b110, 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule